// File: doc/BRIEF.md
# Receive Byte Queue with Programmable Fill Threshold

This block buffers bytes arriving from a serial-bus sequencer until a register read port collects them. It holds up to sixteen 8-bit entries and returns them strictly in arrival order. Each strobe on the read port removes one byte. The byte appears on the read-data output one cycle after the strobe.

Software programs a zero-based fill threshold. Writing N-1 makes the block raise a level signal, `thresh_hit`, once N or more bytes are held. The level stays true while that condition holds, so it comes back after an interrupt clear if enough bytes are still waiting. The threshold may be rewritten between reads to follow the bytes left in a message. Software can therefore hold back the final byte of a read and handle it apart from the others. The block also reports an occupancy value (held bytes minus one), separate full and empty flags, and a sticky overflow flag. The overflow flag sets when an arriving byte finds no room.

Control is a three-state machine:
- `ST_EMPTY`: nothing held.
- `ST_PART`: between one and fifteen bytes held.
- `ST_FULL`: sixteen bytes held.

Its named transitions are:
- FILL_FIRST: `ST_EMPTY` to `ST_PART`, taken by a push.
- DRAIN_LAST: `ST_PART` to `ST_EMPTY`, taken when the last byte is popped.
- FILL_TOP: `ST_PART` to `ST_FULL`, taken when the sixteenth byte is pushed.
- DRAIN_TOP: `ST_FULL` to `ST_PART`, taken by a pop without a push.

In every other case the state holds.

Top module: `rx_wm_fifo`

## Requirements
- R1: After reset the block reports empty=1, full=0, occupancy=0, thresh_hit=0, overflow=0 and rd_data=0, and the threshold register holds 15.
- R2: Bytes come out of rd_data in the order they were pushed. The byte appears in the cycle after the pop strobe is sampled.
- R3: A push while 16 bytes are held and no pop is taken is discarded. It sets `overflow`, which stays 1 until reset.
- R4: A pop while empty leaves rd_data at its previous value and changes no count or flag.
- R5: `occupancy` equals the held count minus one, and reads 0 when the queue is empty.
- R6: `empty` is 1 exactly when 0 bytes are held. `full` is 1 exactly when 16 bytes are held.
- R7: `thresh_hit` is 1 exactly when the held count is greater than the threshold register value. It re-asserts whenever that condition becomes true again.
- R8: A threshold write (4-bit value) takes effect for the comparison from the cycle after it is sampled.
- R9: A push and a pop in the same cycle while full are both taken. The count stays at 16 and overflow is not set.
- R10: The state machine moves between `ST_EMPTY`, `ST_PART` and `ST_FULL` only through FILL_FIRST, DRAIN_LAST, FILL_TOP and DRAIN_TOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push | input | 1 | Store `push_data` this cycle |
| push_data | input | 8 | Byte from the sequencer |
| pop | input | 1 | Read strobe; removes the oldest byte |
| rd_data | output | 8 | Last byte removed |
| thresh_we | input | 1 | Load the threshold register |
| thresh_val | input | 4 | Zero-based threshold value |
| occupancy | output | 4 | Held count minus one (0 when empty) |
| empty | output | 1 | No bytes held |
| full | output | 1 | Sixteen bytes held |
| thresh_hit | output | 1 | Held count exceeds threshold |
| overflow | output | 1 | Sticky: a byte was dropped |

## Verification
The bench aims at these corner cases:
- Boundary of the threshold comparison. An off-by-one compare would raise `thresh_hit` a byte early or a byte late.
- Re-assertion after the level falls and the count rises again. A latched, edge-style flag would stay low.
- Push at exactly sixteen bytes, alone and together with a pop. Getting this wrong either overwrites the oldest byte or wrongly drops a byte during a simultaneous read.
- Pops on an empty queue. A pointer that moves on an empty read would corrupt the next byte returned.
- A threshold rewrite halfway through draining. This shows whether a new threshold applies at once against the present count.

// File: rtl/rx_wm_pkg.sv
package rx_wm_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_PART  = 2'd1,
        ST_FULL  = 2'd2
    } rxq_state_e;
endpackage

// File: rtl/rx_wm_store.sv
module rx_wm_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_ptr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_ptr,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    // Read register: holds its value unless a real pop was taken.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_ptr];
    end

    assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/rx_wm_ctrl.sv
module rx_wm_ctrl
    import rx_wm_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic          wr_en,
    output logic          rd_en,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full,
    output logic          overflow
);
    localparam logic [CW-1:0] CNT_MAX  = CW'(DEPTH);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    rxq_state_e state, state_nxt;
    logic       pop_ok, push_ok, drop;
    logic [CW-1:0] count_nxt;

    assign pop_ok    = pop && (state != ST_EMPTY);
    assign push_ok   = push && ((state != ST_FULL) || pop_ok);
    assign drop      = push && !push_ok;
    assign wr_en     = push_ok;
    assign rd_en     = pop_ok;
    assign count_nxt = count + CW'(push_ok) - CW'(pop_ok);

    // Transition logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_EMPTY: if (push_ok) state_nxt = ST_PART;            // FILL_FIRST
            ST_PART: begin
                if (count_nxt == '0)          state_nxt = ST_EMPTY; // DRAIN_LAST
                else if (count_nxt == CNT_MAX) state_nxt = ST_FULL; // FILL_TOP
            end
            ST_FULL:  if (pop_ok && !push_ok) state_nxt = ST_PART; // DRAIN_TOP
            default:  state_nxt = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nxt;
    end

    // Output decode
    always_comb begin
        empty = 1'b0;
        full  = 1'b0;
        unique case (state)
            ST_EMPTY: empty = 1'b1;
            ST_PART:  ;
            ST_FULL:  full = 1'b1;
            default:  empty = 1'b1;
        endcase
    end

    // Pointers, count and sticky drop flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            count <= count_nxt;
            if (drop) overflow <= 1'b1;
        end
    end

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_MAX);
    assert_flags_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count == CNT_MAX) && overflow);
    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty && $stable(rd_ptr));
    assert_full_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && pop) |=> full && $stable(overflow));
    assert_state_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({state == ST_EMPTY, state == ST_PART, state == ST_FULL}) &&
        (state != 2'd3));
endmodule

// File: rtl/rx_wm_level.sv
module rx_wm_level #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wm_we,
    input  logic [AW-1:0] wm_in,
    input  logic [CW-1:0] count,
    output logic          hit
);
    logic [AW-1:0] wm_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     wm_q <= AW'(DEPTH - 1);
        else if (wm_we) wm_q <= wm_in;
    end

    // Level, not a latched event: follows count and threshold every cycle.
    assign hit = count > CW'(wm_q);

    assert_wm_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wm_we |=> (wm_q == $past(wm_in)));
    assert_hit_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !hit);
endmodule

// File: rtl/rx_wm_fifo.sv
module rx_wm_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] rd_data,
    input  logic             thresh_we,
    input  logic [AW-1:0]    thresh_val,
    output logic [AW-1:0]    occupancy,
    output logic             empty,
    output logic             full,
    output logic             thresh_hit,
    output logic             overflow
);
    logic          wr_en, rd_en;
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    rx_wm_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .wr_en(wr_en), .rd_en(rd_en), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .count(count), .empty(empty), .full(full), .overflow(overflow)
    );

    rx_wm_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(wr_ptr),
        .wr_data(push_data), .rd_en(rd_en), .rd_ptr(rd_ptr), .rd_data(rd_data)
    );

    rx_wm_level #(.DEPTH(DEPTH)) u_level (
        .clk(clk), .rst_n(rst_n), .wm_we(thresh_we), .wm_in(thresh_val),
        .count(count), .hit(thresh_hit)
    );

    logic [CW-1:0] count_m1;
    assign count_m1  = count - 1'b1;
    assign occupancy = empty ? '0 : count_m1[AW-1:0];

    assert_occ_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (occupancy == '0));
endmodule

// File: tb/rx_wm_fifo_bench.sv
module rx_wm_fifo_bench;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n, push, pop, thresh_we;
    logic [7:0] push_data, rd_data;
    logic [3:0] thresh_val, occupancy;
    logic       empty, full, thresh_hit, overflow;

    rx_wm_fifo u_rx_wm_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .pop(pop), .rd_data(rd_data), .thresh_we(thresh_we),
        .thresh_val(thresh_val), .occupancy(occupancy), .empty(empty),
        .full(full), .thresh_hit(thresh_hit), .overflow(overflow)
    );

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] exp_q[$];   // scoreboard of bytes expected out
    int   m_cnt = 0;
    int   m_wm  = 15;
    bit   m_ovf = 0;
    logic [7:0] m_last = 8'h00;
    bit   mon_on = 0;
    logic c_push = 0, c_pop = 0, c_we = 0;
    logic [7:0] c_d = 0;
    logic [3:0] c_wd = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Capture what the design sampled
    always @(posedge clk) begin
        c_push <= push; c_pop <= pop; c_d <= push_data;
        c_we <= thresh_we; c_wd <= thresh_val;
    end

    // Monitor: update reference model, compare outputs away from the edge
    always @(negedge clk) begin
        if (mon_on) begin
            bit pop_ok, push_ok;
            pop_ok  = c_pop && (m_cnt > 0);
            push_ok = c_push && ((m_cnt < 16) || pop_ok);
            if (pop_ok) begin
                m_last = exp_q.pop_front();
                chk("R2 order", rd_data, m_last);
            end else if (c_pop) begin
                chk("R4 empty pop keeps rd_data", rd_data, m_last);
            end
            if (push_ok) exp_q.push_back(c_d);
            if (c_push && !push_ok) m_ovf = 1;
            m_cnt = m_cnt + int'(push_ok) - int'(pop_ok);
            if (c_we) m_wm = c_wd;
            chk("R6 empty", empty, m_cnt == 0);
            chk("R6 full", full, m_cnt == 16);
            chk("R5 occupancy", occupancy, (m_cnt == 0) ? 0 : m_cnt - 1);
            chk("R7 R8 thresh_hit", thresh_hit, m_cnt > m_wm);
            chk("R3 overflow", overflow, m_ovf);
        end
    end

    task automatic cyc(bit p, logic [7:0] d, bit r);
        @(negedge clk);
        push = p; push_data = d; pop = r;
        @(negedge clk);
        push = 0; pop = 0;
    endtask

    task automatic set_wm(logic [3:0] v);
        @(negedge clk);
        thresh_we = 1; thresh_val = v;
        @(negedge clk);
        thresh_we = 0;
    endtask

    initial begin
        rst_n = 0; push = 0; pop = 0; thresh_we = 0;
        push_data = 0; thresh_val = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 empty", empty, 1); chk("R1 full", full, 0);
        chk("R1 occ", occupancy, 0); chk("R1 hit", thresh_hit, 0);
        chk("R1 ovf", overflow, 0); chk("R1 rd_data", rd_data, 0);
        rst_n = 1;
        mon_on = 1;
        // R2 ordering, distinct patterns
        for (int i = 0; i < 5; i++) cyc(1, 8'hA0 + 8'(i * 7), 0);
        for (int i = 0; i < 5; i++) cyc(0, 0, 1);
        // R4 pops while empty
        cyc(0, 0, 1); cyc(0, 0, 1);
        // R7 default threshold: hit only at 16; R10 FILL_TOP
        for (int i = 0; i < 16; i++) cyc(1, 8'(i * 13 + 1), 0);
        chk("R6 R10 full reached", full, 1);
        chk("R7 hit at 16", thresh_hit, 1);
        // R9 push+pop while full
        cyc(1, 8'h5C, 1);
        chk("R9 still full no ovf", {full, overflow}, 2'b10);
        // R3 push while full is dropped
        cyc(1, 8'hEE, 0);
        chk("R3 sticky set", overflow, 1);
        // R8 rewrite threshold while draining: value 3 -> hit while >3 held
        set_wm(4'd3);
        for (int i = 0; i < 14; i++) cyc(0, 0, 1);
        chk("R7 below threshold", thresh_hit, 0);
        cyc(1, 8'h31, 0); cyc(1, 8'h32, 0);
        chk("R7 re-asserts", thresh_hit, 1);
        // R8 threshold 0: hit with a single byte
        set_wm(4'd0);
        for (int i = 0; i < 3; i++) cyc(0, 0, 1);
        chk("R7 one byte thr0", thresh_hit, 1);
        cyc(0, 0, 1);
        chk("R10 DRAIN_LAST", empty, 1);
        cyc(0, 0, 1);
        chk("R3 overflow holds", overflow, 1);
        mon_on = 0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule